// File: doc/BRIEF.md
# CAN Fault Confinement Tracker

This block keeps the transmit and receive error counts of a Controller Area Network node and turns them into the node's fault-confinement state. The protocol engine around it reports events as single-cycle strobes: a transmit error, a receive error, a successful transmission and a successful reception. The block updates the two counts from those strobes and classifies the node as error active, warning, error passive or bus-off. The outputs tell the rest of the controller how to behave. They say which kind of error flag to send, whether a pending transmission must wait, and whether the bus drivers must be switched off. An interrupt pulse marks every change of state.

Recovery from bus-off relies on a sampled bus bit and a bit-time strobe. While the node is bus-off, the block counts runs of eleven consecutive recessive samples. After 128 such runs it clears both counts, and the node becomes error active again. The same sampled bit also times the extra idle period that an error-passive node must wait out before it may transmit.

Top module: `can_fault_confine`

## Requirements
- R1: After a synchronous reset, both counts are 0, `state_o` is 0 (error active), and `irq_o`, `drv_off_o`, `passive_flag_o` and `suspend_o` are all low.
- R2: A transmit-error strobe adds 8 to the 9-bit transmit count. A successful-transmission strobe subtracts 1, but never below 0. When both strobes arrive in the same cycle, the error wins.
- R3: A receive-error strobe adds 1 to the 8-bit receive count, which stops at 255. A successful-reception strobe subtracts 1, but never below 0. When both strobes arrive in the same cycle, the error wins.
- R4: `state_o` is 0 (error active) while both counts are below 96. It is 1 (warning) when either count is 96 or more and the node is neither error passive nor bus-off.
- R5: `state_o` is 2 (error passive) when the transmit count is from 128 to 255, or when the receive count is 128 or more. `passive_flag_o` is high exactly in this state.
- R6: `state_o` is 3 (bus-off) and `drv_off_o` is high once the transmit count exceeds 255. From the cycle the count exceeds 255, every counter strobe is ignored.
- R7: Receive errors alone never cause bus-off. A receive count held at 255 leaves the node error passive.
- R8: A recessive sample is a bus bit of 1 taken on a bit-time strobe. While the node is bus-off, every 11 consecutive recessive samples make one run, and a dominant sample restarts the current run. Samples taken outside bus-off count for nothing. On the sample that completes the 128th run, both counts become 0.
- R9: In error passive with a transmit request held, `suspend_o` stays high until 8 recessive samples have followed the request. A dominant sample restarts that count. Outside error passive, or with no request, `suspend_o` is low.
- R10: `state_o` follows the counts one cycle later. `irq_o` is high for exactly the first cycle in which `state_o` shows a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_err_i | input | 1 | Transmit error strobe |
| rx_err_i | input | 1 | Receive error strobe |
| tx_ok_i | input | 1 | Successful transmission strobe |
| rx_ok_i | input | 1 | Successful reception strobe |
| bit_tick_i | input | 1 | One pulse per bit time, qualifies `bus_bit_i` |
| bus_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| tx_req_i | input | 1 | The node has a frame waiting to transmit |
| tec_o | output | 9 | Transmit error count |
| rec_o | output | 8 | Receive error count |
| state_o | output | 2 | 0 active, 1 warning, 2 passive, 3 bus-off |
| passive_flag_o | output | 1 | Error flags are to be of the passive kind |
| suspend_o | output | 1 | Hold off the pending transmission |
| drv_off_o | output | 1 | Switch off the bus drivers |
| irq_o | output | 1 | One-cycle pulse on each state change |

## Verification
The bench drives each count up to the exact thresholds, at 95/96 and 120/128 and 248/256, because a design with an off-by-one compare would change state one error early or one error late. It pushes the receive count far past 255 to confirm that the count saturates and that the node stays passive; a design that wrapped the count or let it reach bus-off would fail here. For recovery, it breaks one run with a dominant bit and feeds recessive bits during error passive before bus-off. A design that ignored the restart, or counted runs outside bus-off, would then recover too early. It also applies success strobes while the node is bus-off, and a design that kept counting would decrement its way out of bus-off.

// File: rtl/fconf_pkg.sv
package fconf_pkg;

    localparam int CNT_W = 8;
    localparam int TEC_W = CNT_W + 1;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_WARN    = 2'd1,
        ST_PASSIVE = 2'd2,
        ST_BUSOFF  = 2'd3
    } fc_state_e;

    typedef struct packed {
        logic tx_err;
        logic rx_err;
        logic tx_ok;
        logic rx_ok;
    } fc_events_t;

    // Derive confinement state; transmit count alone reaches bus-off.
    function automatic fc_state_e classify(
        input logic [TEC_W-1:0] tec,
        input logic [CNT_W-1:0] rec,
        input int               warn_lim,
        input int               pass_lim
    );
        logic [TEC_W-1:0] rec_x;
        rec_x = {1'b0, rec};
        if (tec[TEC_W-1])
            return ST_BUSOFF;
        else if (tec >= TEC_W'(pass_lim) || rec_x >= TEC_W'(pass_lim))
            return ST_PASSIVE;
        else if (tec >= TEC_W'(warn_lim) || rec_x >= TEC_W'(warn_lim))
            return ST_WARN;
        else
            return ST_ACTIVE;
    endfunction

endpackage

// File: rtl/fconf_err_counters.sv
module fconf_err_counters
    import fconf_pkg::*;
#(
    parameter int TX_STEP = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  fc_events_t          ev,
    input  logic                clear,
    output logic [TEC_W-1:0]    tec,
    output logic [CNT_W-1:0]    rec,
    output logic                over
);
    logic [TEC_W-1:0] tec_q;
    logic [CNT_W-1:0] rec_q;

    assign over = tec_q[TEC_W-1];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            tec_q <= '0;
            rec_q <= '0;
        end else if (!over) begin
            if (ev.tx_err)
                tec_q <= tec_q + TEC_W'(TX_STEP);
            else if (ev.tx_ok && tec_q != '0)
                tec_q <= tec_q - 1'b1;

            if (ev.rx_err) begin
                if (rec_q != '1)
                    rec_q <= rec_q + 1'b1;
            end else if (ev.rx_ok && rec_q != '0) begin
                rec_q <= rec_q - 1'b1;
            end
        end
    end

    assign tec = tec_q;
    assign rec = rec_q;
endmodule

// File: rtl/fconf_recess_mon.sv
module fconf_recess_mon #(
    parameter int RUN_LEN   = 11,
    parameter int RUN_COUNT = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    input  logic bus_bit,
    output logic done
);
    localparam int RUN_W = $clog2(RUN_LEN);
    localparam int OCC_W = $clog2(RUN_COUNT);

    logic [RUN_W-1:0] run_q;
    logic [OCC_W-1:0] occ_q;
    logic             run_end;

    assign run_end = en && tick && bus_bit && (run_q == RUN_W'(RUN_LEN - 1));
    assign done    = run_end && (occ_q == OCC_W'(RUN_COUNT - 1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            run_q <= '0;
            occ_q <= '0;
        end else if (tick) begin
            if (!bus_bit) begin
                run_q <= '0;
            end else if (run_end) begin
                run_q <= '0;
                occ_q <= occ_q + 1'b1;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fconf_suspend.sv
module fconf_suspend #(
    parameter int IDLE_BITS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    input  logic bus_bit,
    output logic hold
);
    localparam int IW = $clog2(IDLE_BITS + 1);

    logic [IW-1:0] idle_q;

    always_ff @(posedge clk) begin
        if (rst || !en)
            idle_q <= '0;
        else if (tick) begin
            if (!bus_bit)
                idle_q <= '0;
            else if (idle_q != IW'(IDLE_BITS))
                idle_q <= idle_q + 1'b1;
        end
    end

    assign hold = en && (idle_q != IW'(IDLE_BITS));
endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
    import fconf_pkg::*;
#(
    parameter int WARN_LIM  = 96,
    parameter int PASS_LIM  = 128,
    parameter int TX_STEP   = 8,
    parameter int RUN_LEN   = 11,
    parameter int RUN_COUNT = 128,
    parameter int IDLE_BITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_err_i,
    input  logic             rx_err_i,
    input  logic             tx_ok_i,
    input  logic             rx_ok_i,
    input  logic             bit_tick_i,
    input  logic             bus_bit_i,
    input  logic             tx_req_i,
    output logic [TEC_W-1:0] tec_o,
    output logic [CNT_W-1:0] rec_o,
    output logic [1:0]       state_o,
    output logic             passive_flag_o,
    output logic             suspend_o,
    output logic             drv_off_o,
    output logic             irq_o
);
    fc_events_t ev;
    fc_state_e  state_q, state_d;
    logic       irq_q;
    logic       over, recovered;
    logic [TEC_W-1:0] tec;
    logic [CNT_W-1:0] rec;

    assign ev = '{tx_err: tx_err_i, rx_err: rx_err_i, tx_ok: tx_ok_i, rx_ok: rx_ok_i};

    fconf_err_counters #(.TX_STEP(TX_STEP)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .clear (recovered),
        .tec   (tec),
        .rec   (rec),
        .over  (over)
    );

    fconf_recess_mon #(.RUN_LEN(RUN_LEN), .RUN_COUNT(RUN_COUNT)) u_mon (
        .clk     (clk),
        .rst     (rst),
        .en      (over),
        .tick    (bit_tick_i),
        .bus_bit (bus_bit_i),
        .done    (recovered)
    );

    fconf_suspend #(.IDLE_BITS(IDLE_BITS)) u_susp (
        .clk     (clk),
        .rst     (rst),
        .en      (tx_req_i && state_q == ST_PASSIVE),
        .tick    (bit_tick_i),
        .bus_bit (bus_bit_i),
        .hold    (suspend_o)
    );

    assign state_d = classify(tec, rec, WARN_LIM, PASS_LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ACTIVE;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= (state_d != state_q);
        end
    end

    assign tec_o          = tec;
    assign rec_o          = rec;
    assign state_o        = state_q;
    assign irq_o          = irq_q;
    assign passive_flag_o = (state_q == ST_PASSIVE);
    assign drv_off_o      = (state_q == ST_BUSOFF);
endmodule

// File: rtl/fconf_checker.sv
module fconf_checker
    import fconf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [TEC_W-1:0] tec_o,
    input logic [CNT_W-1:0] rec_o,
    input logic [1:0]       state_o,
    input logic             passive_flag_o,
    input logic             suspend_o,
    input logic             drv_off_o,
    input logic             irq_o
);
    // R6: a count past 255 shows up as bus-off one cycle later
    assert_busoff_entry_R6: assert property (@(posedge clk) disable iff (rst)
        tec_o[TEC_W-1] |=> (state_o == ST_BUSOFF));

    // R7: bus-off is only ever entered from an overflowed transmit count
    assert_rx_no_busoff_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_off_o) |-> $past(tec_o[TEC_W-1]));

    // R5: passive entry needs a count at the passive threshold
    assert_passive_entry_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(passive_flag_o) |-> ($past(tec_o) >= 9'd128 || $past(rec_o) >= 8'd128));

    // R10: interrupt marks exactly the cycles where the state moved
    assert_irq_on_change_R10: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (state_o != $past(state_o)));
    assert_change_has_irq_R10: assert property (@(posedge clk) disable iff (rst)
        (state_o != $past(state_o)) |-> irq_o);

    // R2: transmit count moves only by +8, -1 or a clear to zero
    assert_tec_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tec_o != $past(tec_o)) |->
            (tec_o == $past(tec_o) + 9'd8 || tec_o == $past(tec_o) - 9'd1 || tec_o == '0));

    // R9: suspension is only requested by a passive node
    assert_suspend_passive_R9: assert property (@(posedge clk) disable iff (rst)
        suspend_o |-> (state_o == ST_PASSIVE));
endmodule

bind can_fault_confine fconf_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .tec_o          (tec_o),
    .rec_o          (rec_o),
    .state_o        (state_o),
    .passive_flag_o (passive_flag_o),
    .suspend_o      (suspend_o),
    .drv_off_o      (drv_off_o),
    .irq_o          (irq_o)
);

// File: tb/tb_can_fault_confine.sv
module tb_can_fault_confine;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_err = 0, rx_err = 0, tx_ok = 0, rx_ok = 0;
    logic bit_tick = 0, bus_bit = 1, tx_req = 0;
    logic [8:0] tec;
    logic [7:0] rec;
    logic [1:0] state;
    logic passive_flag, suspend, drv_off, irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    can_fault_confine dut (
        .clk(clk), .rst(rst),
        .tx_err_i(tx_err), .rx_err_i(rx_err), .tx_ok_i(tx_ok), .rx_ok_i(rx_ok),
        .bit_tick_i(bit_tick), .bus_bit_i(bus_bit), .tx_req_i(tx_req),
        .tec_o(tec), .rec_o(rec), .state_o(state),
        .passive_flag_o(passive_flag), .suspend_o(suspend),
        .drv_off_o(drv_off), .irq_o(irq)
    );

    // {tx_err, rx_err, tx_ok, rx_ok, expected tec[8:0], expected rec[7:0]}
    localparam logic [20:0] VEC [10] = '{
        {4'b0100, 9'd0,  8'd1},   // R3 rx error
        {4'b0001, 9'd0,  8'd0},   // R3 rx ok
        {4'b0001, 9'd0,  8'd0},   // R3 floor at 0
        {4'b0010, 9'd0,  8'd0},   // R2 floor at 0
        {4'b1000, 9'd8,  8'd0},   // R2 +8
        {4'b1010, 9'd16, 8'd0},   // R2 error wins over ok
        {4'b0010, 9'd15, 8'd0},   // R2 -1
        {4'b0101, 9'd15, 8'd1},   // R3 error wins over ok
        {4'b1100, 9'd23, 8'd2},   // R2 R3 both errors
        {4'b0011, 9'd22, 8'd1}    // R2 R3 both ok
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic te, input logic re, input logic to, input logic ro);
        tx_err = te; rx_err = re; tx_ok = to; rx_ok = ro;
        @(negedge clk);
        tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic tick(input logic b);
        bus_bit = b; bit_tick = 1;
        @(negedge clk);
        bit_tick = 0; bus_bit = 1;
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1 reset state
        check("R1 tec", tec, 0);
        check("R1 rec", rec, 0);
        check("R1 state", state, 0);
        check("R1 irq", irq, 0);
        check("R1 drv_off", drv_off, 0);
        check("R1 passive_flag", passive_flag, 0);
        check("R1 suspend", suspend, 0);

        // R2/R3 vector walk
        for (int i = 0; i < 10; i++) begin
            apply(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17]);
            check("R2 tec vector", tec, int'(VEC[i][16:8]));
            check("R3 rec vector", rec, int'(VEC[i][7:0]));
        end

        // R4 warning threshold on receive count
        do_reset();
        for (int i = 0; i < 95; i++) apply(0, 1, 0, 0);
        idle();
        check("R4 rec 95 active", state, 0);
        apply(0, 1, 0, 0);
        check("R10 state lags count", state, 0);
        idle();
        check("R4 rec 96 warning", state, 1);
        check("R10 irq on change", irq, 1);
        idle();
        check("R10 irq one cycle", irq, 0);

        // R5 passive via receive count
        for (int i = 0; i < 32; i++) apply(0, 1, 0, 0);
        idle();
        check("R5 rec 128 passive", state, 2);
        check("R5 passive flag", passive_flag, 1);

        // R9 suspend timing
        tx_req = 1;
        #1;
        check("R9 suspend on request", suspend, 1);
        for (int i = 0; i < 7; i++) tick(1);
        #1;
        check("R9 suspend after 7 idle bits", suspend, 1);
        tick(1);
        #1;
        check("R9 suspend released after 8", suspend, 0);
        tick(0);
        #1;
        check("R9 dominant restarts wait", suspend, 1);
        tx_req = 0;
        #1;
        check("R9 no request no suspend", suspend, 0);

        // R7 receive saturation, never bus-off
        for (int i = 0; i < 200; i++) apply(0, 1, 0, 0);
        idle();
        check("R3 rec saturates", rec, 255);
        check("R7 rx stays passive", state, 2);
        check("R7 no driver off", drv_off, 0);

        // R4/R5 transmit thresholds
        do_reset();
        for (int i = 0; i < 15; i++) apply(1, 0, 0, 0);
        idle();
        check("R4 tec 120 warning", state, 1);
        apply(1, 0, 0, 0);
        idle();
        check("R5 tec 128 passive", state, 2);
        tx_req = 1;
        #1;
        check("R9 suspend from tx passive", suspend, 1);
        tx_req = 0;
        for (int i = 0; i < 15; i++) apply(1, 0, 0, 0);
        idle();
        check("R5 tec 248 passive", tec, 248);
        check("R5 tec 248 state", state, 2);

        // R8 recessive bits outside bus-off must not count
        for (int i = 0; i < 1400; i++) tick(1);

        // R6 bus-off entry
        apply(1, 0, 0, 0);
        check("R6 tec 256", tec, 256);
        idle();
        check("R6 bus-off state", state, 3);
        check("R6 drivers off", drv_off, 1);
        check("R5 no passive flag in bus-off", passive_flag, 0);
        apply(0, 0, 1, 0);
        check("R6 tx ok ignored", tec, 256);
        apply(0, 1, 0, 0);
        check("R6 rx err ignored", rec, 0);
        apply(1, 0, 0, 0);
        check("R6 tx err ignored", tec, 256);

        // R8 recovery with a broken run
        for (int i = 0; i < 10; i++) tick(1);
        tick(0);
        for (int i = 0; i < 127 * 11 + 10; i++) tick(1);
        idle();
        check("R8 one bit short still bus-off", state, 3);
        check("R8 one bit short tec held", tec, 256);
        tick(1);
        check("R8 tec cleared", tec, 0);
        check("R8 rec cleared", rec, 0);
        idle();
        check("R8 back to active", state, 0);
        check("R10 irq on recovery", irq, 1);
        check("R8 drivers on", drv_off, 0);
        idle();
        check("R10 irq drops", irq, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule